// File: doc/BRIEF.md
# Dual-Source Register Commit Stage

This block is the register-commit stage of a 16-bit signal-processor core. Every instruction word can hold a main operation and, depending on its top nibble, an attached extension operation. The block splits the word into a main field and an 8-bit extension field, and it reports whether an extension is present. The main execution unit and the extension execution unit each offer at most one register write per instruction. Both units compute from the register file as it stood before the instruction. The block stages their writes in two pending buffers and commits both buffers on a single clock edge.

When both units target the same register, the committed value is the bitwise OR of the two results. A configuration input selects a second policy in which the extension result overrides the main result, so the two policies can be compared. The extension unit can never change the program counter. One main field value is a no-op, which lets an extension run on its own. A direct load port presets registers for test.

The control is a two-state machine. `ST_IDLE` holds the register file and accepts direct loads. It moves to `ST_COMMIT` when `instr_valid` is high, otherwise it stays in `ST_IDLE`. `ST_COMMIT` commits the pending buffers on its closing edge. It stays in `ST_COMMIT` if a new instruction is valid on that edge, otherwise it returns to `ST_IDLE`.

Top module: `dual_write_commit`

## Requirements
- R1: A synchronous reset clears all 16 registers to zero and puts the control in `ST_IDLE`.
- R2: For a word whose top nibble (bits 15:12) is 0, 1 or 2: `dec_has_ext` is 0, `dec_main` equals the whole word, and `dec_ext` is 0.
- R3: For a word whose top nibble is 4 or higher: `dec_has_ext` is 1, `dec_ext` is bits 7:0, and `dec_main` is bits 15:8 with bits 7:0 zero.
- R4: For a word whose top nibble is 3: `dec_has_ext` is 1, `dec_ext` is bit 7 forced to 0 followed by bits 6:0, and `dec_main` is bits 15:7 with bits 6:0 zero.
- R5: Write requests sampled at the edge where `instr_valid` is high are committed together on the next edge. The write data derive from the pre-instruction registers, so opposite moves between two registers perform a swap.
- R6: With `ext_override` = 0, when both units write the same register, the committed value is main data OR extension data.
- R7: With `ext_override` = 1, when both units write the same register, the extension data is committed.
- R8: An extension write to register index 15 (the program counter) is discarded. A main write to index 15 is committed.
- R9: When `dec_main` equals 0x8000 (the no-op main field), the main write request is discarded and the extension write still commits.
- R10: For a word without an extension, the extension write request is discarded.
- R11: While `instr_valid` is low, write requests are ignored and the registers keep their values.
- R12: A direct load changes its register one edge later when the control is in `ST_IDLE`. A load raised during `ST_COMMIT` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word and write requests are valid |
| instr_word | input | 16 | Instruction word |
| ext_override | input | 1 | 0: OR merge on a shared register; 1: extension result wins |
| main_we | input | 1 | Main unit write request |
| main_idx | input | 4 | Main unit target register |
| main_data | input | 16 | Main unit result |
| ext_we | input | 1 | Extension unit write request |
| ext_idx | input | 4 | Extension unit target register |
| ext_data | input | 16 | Extension unit result |
| load_we | input | 1 | Direct test load enable |
| load_idx | input | 4 | Direct load target register |
| load_data | input | 16 | Direct load value |
| rf_flat | output | 256 | Register file, register i at bits 16*i+15:16*i |
| dec_main | output | 16 | Main field of the word, extension bits cleared |
| dec_ext | output | 8 | Extension field |
| dec_has_ext | output | 1 | Word carries an extension |

## Verification
The assertions check, on every cycle, the following behaviours:
- the reset clear;
- that the main and extension fields split the word without overlap;
- the OR and override results on a shared target;
- that a commit without a main program-counter write leaves the program counter alone;
- that the registers hold and the control stays idle while no instruction and no load arrives.

Only the bench's scenarios can show the following:
- the swap arising from the shared snapshot;
- the discard of writes for no-op and extension-free words;
- a load being ignored during a commit;
- agreement of whole register contents with an independent model over long random instruction streams.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int DW   = 16;
    localparam int IW   = 4;
    localparam int NREG = 1 << IW;
    localparam int EXTW = 8;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } pend_t;
endpackage

// File: rtl/dwc_decode.sv
module dwc_decode
    import dwc_pkg::*;
(
    input  logic [DW-1:0]   word,
    output logic [DW-1:0]   main_field,
    output logic [EXTW-1:0] ext_field,
    output logic            has_ext
);
    localparam int NIB_LO = DW - 4;

    logic [3:0] nib;

    always_comb begin
        nib = word[DW-1:NIB_LO];
        if (nib < 4'd3) begin
            has_ext    = 1'b0;
            main_field = word;
            ext_field  = '0;
        end else if (nib == 4'd3) begin
            has_ext    = 1'b1;
            main_field = {word[DW-1:EXTW-1], {(EXTW-1){1'b0}}};
            ext_field  = {1'b0, word[EXTW-2:0]};
        end else begin
            has_ext    = 1'b1;
            main_field = {word[DW-1:EXTW], {EXTW{1'b0}}};
            ext_field  = word[EXTW-1:0];
        end
    end

    // R3 / R4: fields never overlap and together cover the word
    always_comb begin
        if (has_ext) begin
            assert_split_R3: assert (((main_field | {{(DW-EXTW){1'b0}}, ext_field}) == word) &&
                                     ((main_field & {{(DW-EXTW){1'b0}}, ext_field}) == '0))
                else $error("field split mismatch");
        end
    end
endmodule

// File: rtl/dwc_pending.sv
module dwc_pending
    import dwc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          clear,
    input  logic          req_ok,
    input  logic [IW-1:0] req_idx,
    input  logic [DW-1:0] req_data,
    output pend_t         pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (capture) begin
            pend.valid <= req_ok;
            pend.idx   <= req_idx;
            pend.data  <= req_data;
        end else if (clear) begin
            pend.valid <= 1'b0;
        end
    end

    // R11: an empty buffer never becomes valid without a capture
    assert_no_spurious_fill_R11: assert property (@(posedge clk) disable iff (rst)
        (!capture && !pend.valid) |=> !pend.valid);
endmodule

// File: rtl/dwc_merge.sv
module dwc_merge
    import dwc_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] rf_q,
    input  pend_t                   pm,
    input  pend_t                   pe,
    input  logic                    override_q,
    output logic [NREG-1:0][DW-1:0] rf_d
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic m_hit;
        logic e_hit;
        always_comb begin
            m_hit = pm.valid && (pm.idx == IW'(g));
            e_hit = pe.valid && (pe.idx == IW'(g));
            unique case ({m_hit, e_hit})
                2'b11:   rf_d[g] = override_q ? pe.data : (pm.data | pe.data);
                2'b10:   rf_d[g] = pm.data;
                2'b01:   rf_d[g] = pe.data;
                default: rf_d[g] = rf_q[g];
            endcase
        end
    end
endmodule

// File: rtl/dual_write_commit.sv
module dual_write_commit
    import dwc_pkg::*;
#(
    parameter int          PC_IDX   = 15,
    parameter logic [15:0] NOP_MAIN = 16'h8000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [DW-1:0]        instr_word,
    input  logic                 ext_override,
    input  logic                 main_we,
    input  logic [IW-1:0]        main_idx,
    input  logic [DW-1:0]        main_data,
    input  logic                 ext_we,
    input  logic [IW-1:0]        ext_idx,
    input  logic [DW-1:0]        ext_data,
    input  logic                 load_we,
    input  logic [IW-1:0]        load_idx,
    input  logic [DW-1:0]        load_data,
    output logic [NREG*DW-1:0]   rf_flat,
    output logic [DW-1:0]        dec_main,
    output logic [EXTW-1:0]      dec_ext,
    output logic                 dec_has_ext
);
    localparam logic [IW-1:0] PC_I = IW'(PC_IDX);

    ctl_state_t              state_q, state_d;
    logic                    commit_en, load_en, capture;
    logic                    main_ok, ext_ok;
    logic                    override_q;
    pend_t                   pend_m, pend_e;
    logic [NREG-1:0][DW-1:0] rf_q, rf_d;

    dwc_decode i_decode (
        .word       (instr_word),
        .main_field (dec_main),
        .ext_field  (dec_ext),
        .has_ext    (dec_has_ext)
    );

    // qualify requests before staging
    always_comb begin
        capture = instr_valid;
        main_ok = main_we && (dec_main != NOP_MAIN);
        ext_ok  = ext_we && dec_has_ext && (ext_idx != PC_I);
    end

    dwc_pending i_pend_main (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .clear    (commit_en),
        .req_ok   (main_ok),
        .req_idx  (main_idx),
        .req_data (main_data),
        .pend     (pend_m)
    );

    dwc_pending i_pend_ext (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .clear    (commit_en),
        .req_ok   (ext_ok),
        .req_idx  (ext_idx),
        .req_data (ext_data),
        .pend     (pend_e)
    );

    always_ff @(posedge clk) begin
        if (rst)          override_q <= 1'b0;
        else if (capture) override_q <= ext_override;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        commit_en = 1'b0;
        load_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_en = load_we;
                if (instr_valid) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                commit_en = 1'b1;
                state_d   = instr_valid ? ST_COMMIT : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    dwc_merge i_merge (
        .rf_q       (rf_q),
        .pm         (pend_m),
        .pe         (pend_e),
        .override_q (override_q),
        .rf_d       (rf_d)
    );

    always_ff @(posedge clk) begin
        if (rst)            rf_q <= '0;
        else if (commit_en) rf_q <= rf_d;
        else if (load_en)   rf_q[load_idx] <= load_data;
    end

    assign rf_flat = rf_q;

    // ---------------- assertions ----------------
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (rf_flat == '0) && (state_q == ST_IDLE));

    assert_or_merge_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT && pend_m.valid && pend_e.valid &&
         pend_m.idx == pend_e.idx && !override_q)
        |=> rf_q[$past(pend_m.idx)] == $past(pend_m.data | pend_e.data));

    assert_override_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT && pend_m.valid && pend_e.valid &&
         pend_m.idx == pend_e.idx && override_q)
        |=> rf_q[$past(pend_m.idx)] == $past(pend_e.data));

    assert_pc_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT && !(pend_m.valid && pend_m.idx == PC_I))
        |=> $stable(rf_q[PC_I]));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !load_we) |=> $stable(rf_flat));

    assert_stay_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !instr_valid) |=> state_q == ST_IDLE);
endmodule

// File: tb/test_dual_write_commit.sv
module test_dual_write_commit;
    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid;
    logic [15:0]  instr_word;
    logic         ext_override;
    logic         main_we, ext_we, load_we;
    logic [3:0]   main_idx, ext_idx, load_idx;
    logic [15:0]  main_data, ext_data, load_data;
    logic [255:0] rf_flat;
    logic [15:0]  dec_main;
    logic [7:0]   dec_ext;
    logic         dec_has_ext;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model [16];

    always #4 clk = ~clk;

    dual_write_commit i_dual_write_commit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .ext_override(ext_override), .main_we(main_we), .main_idx(main_idx),
        .main_data(main_data), .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
        .load_we(load_we), .load_idx(load_idx), .load_data(load_data),
        .rf_flat(rf_flat), .dec_main(dec_main), .dec_ext(dec_ext), .dec_has_ext(dec_has_ext)
    );

    initial begin
        #1_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired: act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic logic [255:0] model_flat();
        logic [255:0] f;
        for (int i = 0; i < 16; i++) f[i*16 +: 16] = model[i];
        return f;
    endfunction

    function automatic logic [24:0] exp_dec(input logic [15:0] w);
        if (w[15:12] < 4'd3)       return {1'b0, w, 8'h00};
        else if (w[15:12] == 4'd3) return {1'b1, w[15:7], 7'b0, 1'b0, w[6:0]};
        else                       return {1'b1, w[15:8], 8'b0, w[7:0]};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_dec(input string tag);
        logic [24:0] e;
        #1;
        e = exp_dec(instr_word);
        chk({dec_has_ext, dec_main, dec_ext} == e, tag, {dec_has_ext, dec_main, dec_ext}, e);
    endtask

    task automatic idle_inputs();
        instr_valid = 0; main_we = 0; ext_we = 0; load_we = 0;
    endtask

    // issue one instruction, update the model, check after commit
    task automatic run_instr(input logic [15:0] w, input logic mode,
                             input logic mwe, input logic [3:0] mi, input logic [15:0] md,
                             input logic ewe, input logic [3:0] ei, input logic [15:0] ed,
                             input logic lwe, input logic [3:0] li, input logic [15:0] ld,
                             input string tag);
        logic [24:0] d;
        logic mok, eok;
        d   = exp_dec(w);
        mok = mwe && (d[23:8] != 16'h8000);
        eok = ewe && d[24] && (ei != 4'd15);
        if (mok) model[mi] = md;
        if (eok) begin
            if (mok && mi == ei) model[ei] = mode ? ed : (md | ed);
            else                 model[ei] = ed;
        end
        @(negedge clk);
        instr_valid = 1; instr_word = w; ext_override = mode;
        main_we = mwe; main_idx = mi; main_data = md;
        ext_we = ewe; ext_idx = ei; ext_data = ed;
        @(negedge clk);
        idle_inputs();
        load_we = lwe; load_idx = li; load_data = ld;
        @(negedge clk);
        load_we = 0;
        chk(rf_flat == model_flat(), tag, rf_flat, model_flat());
    endtask

    task automatic do_load(input logic [3:0] i, input logic [15:0] v);
        @(negedge clk);
        load_we = 1; load_idx = i; load_data = v;
        @(negedge clk);
        load_we = 0;
        model[i] = v;
        chk(rf_flat == model_flat(), "R12 direct load", rf_flat, model_flat());
    endtask

    initial begin
        int seed;
        logic [15:0] a_old, b_old;
        seed = 32'h5eed;
        void'($urandom(seed));
        rst = 1; idle_inputs(); instr_word = 0; ext_override = 0;
        main_idx = 0; ext_idx = 0; load_idx = 0; main_data = 0; ext_data = 0; load_data = 0;
        for (int i = 0; i < 16; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(rf_flat == '0, "R1 reset clears registers", rf_flat, '0);

        // decode corners
        instr_word = 16'h2abc; chk_dec("R2 nibble 2 no extension");
        instr_word = 16'h0001; chk_dec("R2 nibble 0 no extension");
        instr_word = 16'h3fff; chk_dec("R4 nibble 3 seven-bit extension");
        instr_word = 16'h3080; chk_dec("R4 nibble 3 bit 7 belongs to main");
        instr_word = 16'h4c5a; chk_dec("R3 nibble 4 eight-bit extension");
        instr_word = 16'hf0ff; chk_dec("R3 nibble f");

        // preload
        for (int i = 0; i < 16; i++) do_load(4'(i), 16'h1000 + 16'(i * 16'h0111));

        // R5 swap through shared snapshot
        a_old = model[3]; b_old = model[5];
        run_instr(16'h6113, 0, 1, 4'd3, b_old, 1, 4'd5, a_old, 0, 0, 0, "R5 swap");
        chk(rf_flat[3*16 +: 16] == b_old && rf_flat[5*16 +: 16] == a_old, "R5 swap values",
            {rf_flat[3*16 +: 16], rf_flat[5*16 +: 16]}, {b_old, a_old});

        // R6 OR merge
        run_instr(16'h7660, 0, 1, 4'd8, 16'h0f01, 1, 4'd8, 16'h30a0, 0, 0, 0, "R6 OR merge");
        chk(rf_flat[8*16 +: 16] == 16'h3fa1, "R6 OR value", rf_flat[8*16 +: 16], 16'h3fa1);
        // R7 extension wins
        run_instr(16'h7660, 1, 1, 4'd8, 16'h0f01, 1, 4'd8, 16'h30a0, 0, 0, 0, "R7 override");
        chk(rf_flat[8*16 +: 16] == 16'h30a0, "R7 override value", rf_flat[8*16 +: 16], 16'h30a0);
        // R8 program counter guard
        run_instr(16'h5011, 0, 0, 0, 0, 1, 4'd15, 16'hdead, 0, 0, 0, "R8 extension PC write dropped");
        run_instr(16'h5011, 0, 1, 4'd15, 16'h0042, 0, 0, 0, 0, 0, 0, "R8 main PC write");
        // R9 no-op main
        run_instr(16'h8022, 0, 1, 4'd1, 16'hbeef, 1, 4'd2, 16'h7777, 0, 0, 0, "R9 no-op main, extension alone");
        // R10 no extension
        run_instr(16'h1234, 0, 1, 4'd4, 16'h0404, 1, 4'd6, 16'h6666, 0, 0, 0, "R10 extension dropped");
        // R12 load during commit ignored
        run_instr(16'h4400, 0, 1, 4'd9, 16'h0909, 0, 0, 0, 1, 4'd10, 16'hffff, "R12 load during commit ignored");

        // R11 requests with valid low
        @(negedge clk);
        main_we = 1; main_idx = 4'd0; main_data = 16'hffff;
        ext_we = 1; ext_idx = 4'd1; ext_data = 16'hffff; instr_word = 16'h4000;
        repeat (3) @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk(rf_flat == model_flat(), "R11 valid low ignored", rf_flat, model_flat());

        // random stream
        for (int k = 0; k < 400; k++) begin
            logic [15:0] w;
            logic [3:0] mi, ei;
            w  = 16'($urandom());
            if (k % 7 == 0) w[15:8] = 8'h80;
            mi = 4'($urandom());
            ei = (k % 3 == 0) ? mi : 4'($urandom());
            instr_word = w;
            chk_dec("R2 R3 R4 random decode");
            run_instr(w, 1'($urandom()), 1'($urandom()), mi, 16'($urandom()),
                      1'($urandom()), ei, 16'($urandom()), 0, 0, 0, "R5 R6 R7 random commit");
        end

        // R1 reset again
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 16; i++) model[i] = 0;
        chk(rf_flat == '0, "R1 reset after traffic", rf_flat, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule